// File: doc/BRIEF.md
# Double-Precision Relational Compare Unit

This block compares two IEEE 754 double-precision operands, each carried as a 64-bit word, under one of four predicates chosen by a 2-bit opcode. The four predicates are equal, less than, less than or equal, and unordered. The answer is written as a full 64-bit word, so it can go straight into a register file. A true answer is a fixed nonzero pattern. A false answer is all zero bits.

Operands enter through a valid/ready input channel and answers leave through a valid/ready output channel. With the default `REG_OUT = 1`, a single register stage sits between the two channels. The input side is ready whenever that stage is empty or its content is leaving in the same cycle. Once the output is valid, it holds its value until it is taken. The producer must keep `in_valid` and the operand fields steady until a transfer happens. With `REG_OUT = 0` the unit is purely combinational and the ready signal passes straight through to the input side.

The exception flag output is part of the result interface, but a compare never raises it. This includes operands that are NaNs, whether quiet or signaling.

Top module: `fcmp_unit`

## Requirements
- R1: The opcode encodings are equal = 2'b00, less = 2'b01, less-or-equal = 2'b10 and unordered = 2'b11. Under equal, the answer is true when neither operand is a NaN and both words are bit-identical, or when both are zeros of any sign.
- R2: Every answer is either 64'h4000_0000_0000_0000 (true) or 64'h0 (false).
- R3: A word is a NaN when bits 62:52 are all ones and bits 51:0 are not all zero. When bits 62:52 are all ones and bits 51:0 are zero, the word is an infinity and not a NaN. The unordered predicate is true exactly when at least one operand is a NaN.
- R4: Equal, less and less-or-equal all answer false whenever either operand is a NaN.
- R5: Positive zero (64'h0) and negative zero (64'h8000_0000_0000_0000) compare equal, and neither is less than the other.
- R6: Less is decided by sign and magnitude, with bit 63 as the sign. A negative operand is below any positive operand, except when both are zeros. Between two negative operands, the one with the larger magnitude is the smaller. Minus and plus infinity are the lowest and highest values.
- R7: Less-or-equal is true exactly when less or equal is true.
- R8: `inv_flag` stays low on every answer, including answers for NaN operands.
- R9: A transfer happens on a clock edge where valid and ready are both high. With `REG_OUT = 1`, an answer is valid in the cycle after its operands are accepted. While `out_valid` is high and `out_ready` is low, the answer stays valid and unchanged. `in_ready` is high when the stage is empty or `out_ready` is high.
- R10: While `rst_n` is low, `out_valid` is low. After reset, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair and opcode are present |
| in_ready | output | 1 | Unit can take an operand pair this cycle |
| op | input | 2 | Predicate select (encoding in R1) |
| src_a | input | 64 | Left operand |
| src_b | input | 64 | Right operand |
| out_valid | output | 1 | Answer is present |
| out_ready | input | 1 | Consumer takes the answer this cycle |
| result | output | 64 | True pattern or all zeros |
| inv_flag | output | 1 | Invalid-operation flag, low for compares |

## Verification
With the register stage in place, every answer is due in the first cycle after the edge that accepted its operands. Under back-pressure, it is due in some later cycle, and in order. The driver records a cycle stamp at acceptance, so each scoreboard entry holds the cycle from which the answer may appear. The monitor samples at the falling edge, only when a transfer is about to happen. In phases where the consumer is always ready, the monitor demands the exact cycle; in other phases, it demands no earlier cycle. Whenever the consumer stalls, the monitor also compares the held answer against the previous cycle's answer.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam int unsigned DEF_EXP_W  = 11;
  localparam int unsigned DEF_FRAC_W = 52;

  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_LT = 2'b01,
    CMP_LE = 2'b10,
    CMP_UN = 2'b11
  } cmp_op_e;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
  parameter int unsigned EXP_W  = fcmp_pkg::DEF_EXP_W,
  parameter int unsigned FRAC_W = fcmp_pkg::DEF_FRAC_W,
  localparam int unsigned MAG_W  = EXP_W + FRAC_W,
  localparam int unsigned WORD_W = MAG_W + 1
) (
  input  logic [WORD_W-1:0] word,
  output logic              sign,
  output logic [MAG_W-1:0]  mag,
  output logic              is_nan,
  output logic              is_zero
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign sign   = word[WORD_W-1];
  assign mag    = word[MAG_W-1:0];
  assign exp_f  = word[MAG_W-1:FRAC_W];
  assign frac_f = word[FRAC_W-1:0];

  // all-ones exponent with a nonzero fraction; zero fraction is infinity
  assign is_nan  = (&exp_f) && (|frac_f);
  assign is_zero = ~|mag;

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order #(
  parameter int unsigned MAG_W = fcmp_pkg::DEF_EXP_W + fcmp_pkg::DEF_FRAC_W
) (
  input  logic             sign_a,
  input  logic [MAG_W-1:0] mag_a,
  input  logic             zero_a,
  input  logic             sign_b,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             zero_b,
  output logic             ord_eq,
  output logic             ord_lt
);

  logic both_zero;
  logic mag_below;
  logic mag_above;

  assign both_zero = zero_a && zero_b;
  assign mag_below = mag_a < mag_b;
  assign mag_above = mag_b < mag_a;

  assign ord_eq = both_zero || ((sign_a == sign_b) && (mag_a == mag_b));

  always_comb begin
    if (both_zero) begin
      ord_lt = 1'b0;
    end else if (sign_a != sign_b) begin
      ord_lt = sign_a;
    end else if (sign_a) begin
      ord_lt = mag_above;
    end else begin
      ord_lt = mag_below;
    end
  end

endmodule

// File: rtl/fcmp_stage.sv
module fcmp_stage #(
  parameter int unsigned DATA_W  = 64,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  generate
    if (REG_OUT) begin : g_reg
      logic              full_q;
      logic [DATA_W-1:0] data_q;

      assign in_ready  = !full_q || out_ready;
      assign out_valid = full_q;
      assign out_data  = data_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          full_q <= 1'b0;
          data_q <= '0;
        end else if (in_ready) begin
          full_q <= in_valid;
          if (in_valid) begin
            data_q <= in_data;
          end
        end
      end

      assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

      assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

      assert_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);
    end else begin : g_pass
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit #(
  parameter int unsigned EXP_W   = fcmp_pkg::DEF_EXP_W,
  parameter int unsigned FRAC_W  = fcmp_pkg::DEF_FRAC_W,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned MAG_W  = EXP_W + FRAC_W,
  localparam int unsigned WORD_W = MAG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        op,
  input  logic [WORD_W-1:0] src_a,
  input  logic [WORD_W-1:0] src_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] result,
  output logic              inv_flag
);

  import fcmp_pkg::*;

  // true answer: only the bit just below the sign is set
  localparam logic [WORD_W-1:0] TRUE_WORD = {2'b01, {(WORD_W-2){1'b0}}};

  logic             sgn [2];
  logic [MAG_W-1:0] mag [2];
  logic             nan [2];
  logic             zro [2];
  logic [WORD_W-1:0] opnd [2];

  assign opnd[0] = src_a;
  assign opnd[1] = src_b;

  generate
    for (genvar i = 0; i < 2; i++) begin : g_cls
      fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
        .word    (opnd[i]),
        .sign    (sgn[i]),
        .mag     (mag[i]),
        .is_nan  (nan[i]),
        .is_zero (zro[i])
      );
    end
  endgenerate

  logic ord_eq;
  logic ord_lt;

  fcmp_order #(.MAG_W(MAG_W)) u_ord (
    .sign_a (sgn[0]),
    .mag_a  (mag[0]),
    .zero_a (zro[0]),
    .sign_b (sgn[1]),
    .mag_b  (mag[1]),
    .zero_b (zro[1]),
    .ord_eq (ord_eq),
    .ord_lt (ord_lt)
  );

  logic    unord;
  logic    hit;
  cmp_op_e op_e;

  assign unord = nan[0] || nan[1];
  assign op_e  = cmp_op_e'(op);

  always_comb begin
    unique case (op_e)
      CMP_EQ:  hit = !unord && ord_eq;
      CMP_LT:  hit = !unord && ord_lt;
      CMP_LE:  hit = !unord && (ord_lt || ord_eq);
      default: hit = unord;
    endcase
  end

  logic [WORD_W-1:0] answer;
  assign answer = hit ? TRUE_WORD : '0;

  fcmp_stage #(.DATA_W(WORD_W), .REG_OUT(REG_OUT)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (answer),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (result)
  );

  // compares never signal an exception, NaN operands included
  assign inv_flag = 1'b0;

  assert_nan_false_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && unord && op_e != CMP_UN) |-> !hit);

  assert_zero_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && zro[0] && zro[1]) |-> (ord_eq && !ord_lt));

  assert_eq_lt_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !(ord_eq && ord_lt));

  assert_encoding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (result == '0 || result == TRUE_WORD));

  assert_unord_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_e == CMP_UN && !nan[0] && !nan[1]) |-> !hit);

endmodule

// File: tb/fcmp_unit_bench.sv
module fcmp_unit_bench;

  localparam logic [63:0] TRUE_W = 64'h4000_0000_0000_0000;
  localparam logic [63:0] PZ   = 64'h0000_0000_0000_0000;
  localparam logic [63:0] NZ   = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] MONE = 64'hBFF0_0000_0000_0000;
  localparam logic [63:0] MTWO = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] SNAN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] MNAN = 64'hFFF8_0000_0000_0001;
  localparam logic [63:0] MAXF = 64'h7FEF_FFFF_FFFF_FFFF;
  localparam logic [63:0] TINY = 64'h0000_0000_0000_0001;
  localparam logic [63:0] MTNY = 64'h8000_0000_0000_0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  op = 2'b00;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] result;
  logic        inv_flag;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit bp_en = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] exp_res;
    int          due;
    bit          strict;
    string       tag;
  } item_t;

  item_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  fcmp_unit u_fcmp_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .op        (op),
    .src_a     (src_a),
    .src_b     (src_b),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .result    (result),
    .inv_flag  (inv_flag)
  );

  function automatic bit is_nan(logic [63:0] w);
    return (w[62:52] == 11'h7FF) && (w[51:0] != 52'd0);
  endfunction

  // reference answer from the requirements, using real-number ordering
  function automatic logic [63:0] model(logic [1:0] o, logic [63:0] a, logic [63:0] b);
    real ra, rb;
    bit  un, t;
    un = is_nan(a) || is_nan(b);
    if (un) begin
      t = (o == 2'b11);
    end else begin
      ra = $bitstoreal(a);
      rb = $bitstoreal(b);
      case (o)
        2'b00:   t = (ra == rb);
        2'b01:   t = (ra < rb);
        2'b10:   t = (ra <= rb);
        default: t = 1'b0;
      endcase
    end
    return t ? TRUE_W : 64'd0;
  endfunction

  function automatic string tag_of(logic [1:0] o, logic [63:0] a, logic [63:0] b);
    if (o == 2'b11) return "R3";
    if (is_nan(a) || is_nan(b)) return "R4";
    if (a[62:0] == 63'd0 && b[62:0] == 63'd0) return "R5";
    if (o == 2'b01) return "R6";
    if (o == 2'b10) return "R7";
    return "R1";
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(logic [1:0] o, logic [63:0] a, logic [63:0] b);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    op = o;
    src_a = a;
    src_b = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    it.exp_res = model(o, a, b);
    it.due = cyc + 1;
    it.strict = !bp_en;
    it.tag = tag_of(o, a, b);
    sb.push_back(it);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    idle();
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // consumer ready pattern, updated just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      out_ready = bp_en ? ($urandom_range(0, 2) != 0) : 1'b1;
    end
  end

  // monitor: compares each answer at the moment it is taken
  initial begin
    bit          held_pend = 1'b0;
    logic [63:0] held_val  = '0;
    item_t       it;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (held_pend) begin
          check(out_valid === 1'b1, "R9", "answer dropped under stall", {63'd0, out_valid}, 64'd1);
          check(result === held_val, "R9", "answer changed under stall", result, held_val);
        end
        held_pend = 1'b0;
        check(in_ready === (!out_valid || out_ready), "R9", "in_ready rule", {63'd0, in_ready},
              {63'd0, (!out_valid || out_ready)});
        if (out_valid && !out_ready) begin
          held_pend = 1'b1;
          held_val = result;
        end
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R9", "answer with nothing pending", result, 64'd0);
          end else begin
            it = sb.pop_front();
            check(result === it.exp_res, it.tag, "answer value", result, it.exp_res);
            check(result === 64'd0 || result === TRUE_W, "R2", "answer encoding", result, TRUE_W);
            check(inv_flag === 1'b0, "R8", "flag raised", {63'd0, inv_flag}, 64'd0);
            if (it.strict)
              check(cyc == it.due, "R9", "latency", 64'(cyc), 64'(it.due));
            else
              check(cyc >= it.due, "R9", "early answer", 64'(cyc), 64'(it.due));
          end
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    logic [63:0] vals [15];
    vals = '{PZ, NZ, ONE, TWO, MONE, MTWO, PINF, NINF, QNAN, SNAN, MNAN, MAXF, TINY, MTNY, 64'h4009_21FB_5444_2D18};

    // R10: reset state
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R10", "out_valid in reset", {63'd0, out_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(out_valid === 1'b0, "R10", "out_valid after reset", {63'd0, out_valid}, 64'd0);
    check(in_ready === 1'b1, "R10", "in_ready after reset", {63'd0, in_ready}, 64'd1);

    // R1 R5 R6: directed, consumer always ready, exact latency
    send(2'b00, ONE, ONE);
    send(2'b00, PZ, NZ);
    send(2'b01, NZ, PZ);
    send(2'b01, MTWO, MONE);
    send(2'b01, NINF, MAXF);
    send(2'b01, MAXF, PINF);
    send(2'b11, PINF, NINF);
    send(2'b11, SNAN, ONE);
    send(2'b00, QNAN, QNAN);
    send(2'b10, TWO, TWO);
    drain();

    // every opcode over every pair of the directed values
    for (int i = 0; i < 15; i++)
      for (int j = 0; j < 15; j++)
        for (int k = 0; k < 4; k++)
          send(2'(k), vals[i], vals[j]);
    drain();

    // random operands with back-pressure
    bp_en = 1'b1;
    for (int n = 0; n < 1500; n++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = (n % 3 == 0) ? (a ^ 64'($urandom_range(0, 7))) : {$urandom, $urandom};
      if (n % 5 == 0) b[63] = ~a[63];
      if (n % 17 == 0) begin
        a[62:52] = 11'h7FF;
      end
      send(2'($urandom_range(0, 3)), a, b);
      if (n % 11 == 0) idle();
    end
    drain();
    bp_en = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule